// File: doc/BRIEF.md
# Packed String Compare Engine

This block compares two 128-bit packed operands, A and B, under an 8-bit control byte. It reduces the pairwise element comparisons to one result bit per element position and returns that result both as a set-bit index and as a mask. Each operand is split into 16 bytes or 8 words, read as unsigned or signed. Every element of B is compared with every element of A. The comparisons are then combined under one of four rules: match any element of a set, fall inside a range, compare position by position, or find an ordered substring.

Each operand has a signed length input. Elements at or beyond that length count as past the end of the string. Each pair that contains such an element is forced true or false by a fixed rule that depends on the aggregation mode. The combined result can be inverted, either on all bits or only on the positions where B is valid.

A one-cycle `start` pulse launches a compare. The registered index and mask appear one clock later, marked by `done`, and stay unchanged until the next start.

Top module: `pstr_cmp_engine`

## Requirements
- R1: Control bit 0 picks 16 byte elements (0) or 8 word elements (1). Control bit 1 picks unsigned (0) or signed (1) comparison. Element i occupies bits [8i+7:8i] in byte mode and bits [16i+15:16i] in word mode.
- R2: With control bits [3:2] = 00 (any-match), result bit j is the OR, over every A element i, of the pair result "B[j] equals A[i]".
- R3: With control bits [3:2] = 01 (ranges), A elements are taken in pairs (2m, 2m+1). Result bit j is set when B[j] >= A[2m] and B[j] <= A[2m+1] for at least one pair m.
- R4: With control bits [3:2] = 10 (element-wise), result bit i is the pair result "B[i] equals A[i]".
- R5: With control bits [3:2] = 11 (ordered), result bit j is the AND, over every i with j+i below the element count, of "B[j+i] equals A[i]".
- R6: A pair whose two elements are both invalid is forced false in modes 00 and 01 and forced true in modes 10 and 11. A pair whose A element alone is invalid is forced true in mode 11 and false in the other modes. A pair whose B element alone is invalid is always forced false. Both range comparisons obey these rules.
- R7: An element is valid when its index is less than the magnitude of its operand's signed length, with that magnitude saturated at the element count. For example, -3 behaves like 3, and 100 behaves like the element count.
- R8: Control bits [5:4] set the polarity. 00 and 10 leave the result unchanged. 01 inverts every in-range bit. 11 inverts only the bits whose B element is valid.
- R9: The index output gives the lowest set result bit when control bit 6 is 0, and the highest set result bit when it is 1. When no bit is set, it gives the element count (16 or 8).
- R10: When control bit 6 is 0, the mask output is the result in its low bits, with zeros above. When bit 6 is 1, each result bit fills its whole byte or word of the mask.
- R11: `done` is high exactly one cycle after `start`. Without a start, `idx` and `mask` keep their values. Control bit 7 has no effect.
- R12: During reset, `done`, `idx` and `mask` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a compare with the current inputs |
| ctrl | input | 8 | Control byte: size, sign, mode, polarity, select |
| opa | input | 128 | Operand A (set, ranges or needle) |
| opb | input | 128 | Operand B (string being searched) |
| len_a | input | 8 | Signed length of operand A in elements |
| len_b | input | 8 | Signed length of operand B in elements |
| done | output | 1 | Result valid, one cycle after start |
| idx | output | 5 | Lowest or highest set result bit, or element count if none |
| mask | output | 128 | Compact or expanded result mask |

## Verification
End-of-string forcing and masked inversion both act on the same result bit in the same cycle. Both depend on B validity, so a bit that is forced false can then be flipped by the polarity step. The bench provokes this by sweeping both lengths across zero, mid-string, the element count and beyond, with every polarity code and every mode. The outcome is judged against an arithmetic model that applies forcing first and inversion second. Directed cases with hand-computed masks separate the two steps in one compare.

// File: rtl/pstr_pkg.sv
package pstr_pkg;

    typedef enum logic [1:0] {
        AGG_ANY   = 2'b00,
        AGG_RANGE = 2'b01,
        AGG_EACH  = 2'b10,
        AGG_ORDER = 2'b11
    } agg_mode_e;

    // Control byte fields, MSB first
    typedef struct packed {
        logic       rsvd;
        logic       sel_hi;
        logic [1:0] pol;
        agg_mode_e  agg;
        logic       sgn;
        logic       word;
    } ctrl_t;

    // Override of one pair result when either element lies past its string end
    function automatic logic force_pair(logic raw, logic va, logic vb, agg_mode_e m);
        logic r;
        if (va && vb)        r = raw;
        else if (!va && !vb) r = (m == AGG_EACH) || (m == AGG_ORDER);
        else if (!va)        r = (m == AGG_ORDER);
        else                 r = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/pstr_valid.sv
module pstr_valid #(
    parameter int NB    = 16,
    parameter int LEN_W = 8
) (
    input  logic             word,
    input  logic [LEN_W-1:0] len,
    output logic [NB-1:0]    vld
);
    localparam int NW = NB / 2;

    logic signed [LEN_W:0] len_x;
    logic        [LEN_W:0] mag;

    assign len_x = {len[LEN_W-1], len};
    assign mag   = (len_x < 0) ? (LEN_W+1)'(-len_x) : (LEN_W+1)'(len_x);

    for (genvar i = 0; i < NB; i++) begin : g_v
        if (i < NW) begin : g_lo
            assign vld[i] = (mag > (LEN_W+1)'(i));
        end else begin : g_hi
            assign vld[i] = !word && (mag > (LEN_W+1)'(i));
        end
    end
endmodule

// File: rtl/pstr_pairs.sv
module pstr_pairs #(
    parameter int DATA_W = 128
) (
    input  logic                          word,
    input  logic                          sgn,
    input  logic [DATA_W-1:0]             opa,
    input  logic [DATA_W-1:0]             opb,
    output logic [DATA_W/8-1:0][DATA_W/8-1:0] eq,
    output logic [DATA_W/8-1:0][DATA_W/8-1:0] ge,
    output logic [DATA_W/8-1:0][DATA_W/8-1:0] le
);
    localparam int NB = DATA_W / 8;
    localparam int NW = DATA_W / 16;

    logic [NB-1:0][NB-1:0] b_eq, b_ge, b_le;
    logic [NW-1:0][NW-1:0] w_eq, w_ge, w_le;

    // Byte comparators: index [j][i] = B element j against A element i
    for (genvar j = 0; j < NB; j++) begin : g_bj
        for (genvar i = 0; i < NB; i++) begin : g_bi
            logic signed [8:0] av, bv;
            assign av = {sgn & opa[8*i+7], opa[8*i +: 8]};
            assign bv = {sgn & opb[8*j+7], opb[8*j +: 8]};
            assign b_eq[j][i] = (bv == av);
            assign b_ge[j][i] = (bv >= av);
            assign b_le[j][i] = (bv <= av);
        end
    end

    // Word comparators
    for (genvar j = 0; j < NW; j++) begin : g_wj
        for (genvar i = 0; i < NW; i++) begin : g_wi
            logic signed [16:0] av, bv;
            assign av = {sgn & opa[16*i+15], opa[16*i +: 16]};
            assign bv = {sgn & opb[16*j+15], opb[16*j +: 16]};
            assign w_eq[j][i] = (bv == av);
            assign w_ge[j][i] = (bv >= av);
            assign w_le[j][i] = (bv <= av);
        end
    end

    // Element size selects which matrix feeds aggregation
    for (genvar j = 0; j < NB; j++) begin : g_sj
        for (genvar i = 0; i < NB; i++) begin : g_si
            if (j < NW && i < NW) begin : g_both
                assign eq[j][i] = word ? w_eq[j][i] : b_eq[j][i];
                assign ge[j][i] = word ? w_ge[j][i] : b_ge[j][i];
                assign le[j][i] = word ? w_le[j][i] : b_le[j][i];
            end else begin : g_byte
                assign eq[j][i] = !word && b_eq[j][i];
                assign ge[j][i] = !word && b_ge[j][i];
                assign le[j][i] = !word && b_le[j][i];
            end
        end
    end
endmodule

// File: rtl/pstr_aggregate.sv
module pstr_aggregate
    import pstr_pkg::*;
#(
    parameter int NB = 16
) (
    input  logic [NB-1:0][NB-1:0] eq,
    input  logic [NB-1:0][NB-1:0] ge,
    input  logic [NB-1:0][NB-1:0] le,
    input  logic [NB-1:0]         vld_a,
    input  logic [NB-1:0]         vld_b,
    input  agg_mode_e             agg,
    input  logic                  word,
    input  logic [1:0]            pol,
    output logic [NB-1:0]         res
);
    logic [NB-1:0] raw;

    always_comb begin
        int  n;
        logic acc;
        n   = word ? NB / 2 : NB;
        raw = '0;
        for (int j = 0; j < NB; j++) begin
            acc = 1'b0;
            if (j < n) begin
                unique case (agg)
                    AGG_ANY: begin
                        for (int i = 0; i < NB; i++)
                            if (i < n)
                                acc = acc | force_pair(eq[j][i], vld_a[i], vld_b[j], agg);
                    end
                    AGG_RANGE: begin
                        for (int i = 0; i < NB; i += 2)
                            if (i + 1 < n)
                                acc = acc |
                                      (force_pair(ge[j][i],   vld_a[i],   vld_b[j], agg) &
                                       force_pair(le[j][i+1], vld_a[i+1], vld_b[j], agg));
                    end
                    AGG_EACH: begin
                        acc = force_pair(eq[j][j], vld_a[j], vld_b[j], agg);
                    end
                    AGG_ORDER: begin
                        acc = 1'b1;
                        for (int i = 0; i < NB; i++)
                            if (i < n - j)
                                acc = acc & force_pair(eq[j+i][i], vld_a[i], vld_b[j+i], agg);
                    end
                    default: acc = 1'b0;
                endcase
            end
            raw[j] = acc;
        end
    end

    always_comb begin
        int n;
        n   = word ? NB / 2 : NB;
        res = raw;
        for (int j = 0; j < NB; j++) begin
            if (j < n) begin
                if (pol == 2'b01)      res[j] = ~raw[j];
                else if (pol == 2'b11) res[j] = raw[j] ^ vld_b[j];
            end
        end
    end
endmodule

// File: rtl/pstr_cmp_engine.sv
module pstr_cmp_engine
    import pstr_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int LEN_W  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [7:0]                    ctrl,
    input  logic [DATA_W-1:0]             opa,
    input  logic [DATA_W-1:0]             opb,
    input  logic [LEN_W-1:0]              len_a,
    input  logic [LEN_W-1:0]              len_b,
    output logic                          done,
    output logic [$clog2(DATA_W/8+1)-1:0] idx,
    output logic [DATA_W-1:0]             mask
);
    localparam int NB    = DATA_W / 8;
    localparam int NW    = DATA_W / 16;
    localparam int IDX_W = $clog2(NB + 1);

    typedef struct packed {
        logic             done;
        logic [IDX_W-1:0] idx;
        logic [DATA_W-1:0] mask;
    } out_t;

    ctrl_t cf;
    assign cf = ctrl_t'(ctrl);

    logic unused_rsvd;
    assign unused_rsvd = cf.rsvd;

    logic [NB-1:0]         vld_a, vld_b, res;
    logic [NB-1:0][NB-1:0] eq, ge, le;

    pstr_valid #(.NB(NB), .LEN_W(LEN_W)) u_vld_a (
        .word (cf.word),
        .len  (len_a),
        .vld  (vld_a)
    );

    pstr_valid #(.NB(NB), .LEN_W(LEN_W)) u_vld_b (
        .word (cf.word),
        .len  (len_b),
        .vld  (vld_b)
    );

    pstr_pairs #(.DATA_W(DATA_W)) u_pairs (
        .word (cf.word),
        .sgn  (cf.sgn),
        .opa  (opa),
        .opb  (opb),
        .eq   (eq),
        .ge   (ge),
        .le   (le)
    );

    pstr_aggregate #(.NB(NB)) u_agg (
        .eq    (eq),
        .ge    (ge),
        .le    (le),
        .vld_a (vld_a),
        .vld_b (vld_b),
        .agg   (cf.agg),
        .word  (cf.word),
        .pol   (cf.pol),
        .res   (res)
    );

    out_t st_d, st_q;

    always_comb begin
        logic             found;
        logic [IDX_W-1:0] idx_c;
        logic [DATA_W-1:0] mask_c;

        // Index: element count when nothing is set
        found = 1'b0;
        idx_c = cf.word ? IDX_W'(NW) : IDX_W'(NB);
        if (!cf.sel_hi) begin
            for (int i = 0; i < NB; i++)
                if (!found && res[i]) begin
                    idx_c = IDX_W'(i);
                    found = 1'b1;
                end
        end else begin
            for (int i = NB - 1; i >= 0; i--)
                if (!found && res[i]) begin
                    idx_c = IDX_W'(i);
                    found = 1'b1;
                end
        end

        // Mask: compact, or each bit spread over its element
        mask_c = '0;
        if (!cf.sel_hi) begin
            mask_c = DATA_W'(res);
        end else if (cf.word) begin
            for (int j = 0; j < NW; j++)
                mask_c[16*j +: 16] = {16{res[j]}};
        end else begin
            for (int j = 0; j < NB; j++)
                mask_c[8*j +: 8] = {8{res[j]}};
        end

        st_d      = st_q;
        st_d.done = start;
        if (start) begin
            st_d.idx  = idx_c;
            st_d.mask = mask_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done = st_q.done;
    assign idx  = st_q.idx;
    assign mask = st_q.mask;
endmodule

// File: rtl/pstr_cmp_checker.sv
module pstr_cmp_checker #(
    parameter int DATA_W = 128,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [7:0]        ctrl,
    input logic              done,
    input logic [IDX_W-1:0]  idx,
    input logic [DATA_W-1:0] mask
);
    localparam int NB = DATA_W / 8;

    // R11: a start yields done on the next cycle
    p_done_after_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    // R11: no done without a preceding start
    p_no_spurious_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    // R11: outputs hold while idle
    p_hold_outputs_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(idx) && $stable(mask)));

    // R9: index never exceeds the byte element count
    p_idx_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (idx <= IDX_W'(NB)));

    // R1: word mode index never exceeds eight
    p_word_idx_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(ctrl[0])) |-> (idx <= IDX_W'(NB/2)));

    // R10: compact mask keeps the upper bits clear
    p_compact_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(ctrl[6])) |-> ((mask >> NB) == '0));

    // R9: an empty compact result pairs with the element count index
    p_empty_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(ctrl[6]) && (mask == '0)) |->
        (idx == ($past(ctrl[0]) ? IDX_W'(NB/2) : IDX_W'(NB))));
endmodule

bind pstr_cmp_engine pstr_cmp_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .ctrl  (ctrl),
    .done  (done),
    .idx   (idx),
    .mask  (mask)
);

// File: tb/tb_pstr_cmp_engine.sv
module tb_pstr_cmp_engine;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start;
    logic [7:0]   ctrl;
    logic [127:0] opa, opb;
    logic [7:0]   len_a, len_b;
    logic         done;
    logic [4:0]   idx;
    logic [127:0] mask;

    int n_run  = 0;
    int n_fail = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #(CLK_P/2) clk = ~clk;

    pstr_cmp_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ctrl(ctrl),
        .opa(opa), .opb(opb), .len_a(len_a), .len_b(len_b),
        .done(done), .idx(idx), .mask(mask)
    );

    task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic logic [127:0] small_op();
        logic [127:0] v;
        for (int k = 0; k < 16; k++) begin
            logic [31:0] r;
            r = rnd();
            v[8*k +: 8] = {r[2], 5'b0, r[1:0]};
        end
        return v;
    endfunction

    function automatic logic [127:0] wide_op();
        return {rnd(), rnd(), rnd(), rnd()};
    endfunction

    function automatic int elem(input logic [127:0] v, input int k, input logic [7:0] c);
        int x;
        if (c[0]) begin
            x = int'(v[16*k +: 16]);
            if (c[1] && v[16*k+15]) x = x - 65536;
        end else begin
            x = int'(v[8*k +: 8]);
            if (c[1] && v[8*k+7]) x = x - 256;
        end
        return x;
    endfunction

    function automatic bit fr(input bit raw, input bit va, input bit vb, input int m);
        if (va && vb) return raw;
        if (!va && !vb) return (m >= 2);
        if (!va) return (m == 3);
        return 1'b0;
    endfunction

    // Arithmetic model of the requirements
    task automatic ref_model(input logic [7:0] c, input logic [127:0] a, input logic [127:0] b,
                             input int la, input int lb,
                             output logic [4:0] eidx, output logic [127:0] emask);
        int n, m, ma, mb;
        bit r[16];
        bit va, vb, acc;
        n  = c[0] ? 8 : 16;
        m  = int'(c[3:2]);
        ma = (la < 0) ? -la : la; if (ma > n) ma = n;
        mb = (lb < 0) ? -lb : lb; if (mb > n) mb = n;
        for (int j = 0; j < 16; j++) begin
            r[j] = 1'b0;
            if (j >= n) continue;
            vb = (j < mb);
            if (m == 0) begin
                acc = 0;
                for (int i = 0; i < n; i++)
                    acc |= fr(elem(b,j,c) == elem(a,i,c), i < ma, vb, m);
            end else if (m == 1) begin
                acc = 0;
                for (int i = 0; i < n; i += 2)
                    acc |= fr(elem(b,j,c) >= elem(a,i,c), i < ma, vb, m) &
                           fr(elem(b,j,c) <= elem(a,i+1,c), i + 1 < ma, vb, m);
            end else if (m == 2) begin
                acc = fr(elem(b,j,c) == elem(a,j,c), j < ma, vb, m);
            end else begin
                acc = 1;
                for (int i = 0; i + j < n; i++)
                    acc &= fr(elem(b,j+i,c) == elem(a,i,c), i < ma, (j + i) < mb, m);
            end
            if (c[5:4] == 2'b01) acc = !acc;
            if (c[5:4] == 2'b11 && vb) acc = !acc;
            r[j] = acc;
        end
        eidx = 5'(n);
        if (!c[6]) begin
            for (int j = n - 1; j >= 0; j--) if (r[j]) eidx = 5'(j);
        end else begin
            for (int j = 0; j < n; j++) if (r[j]) eidx = 5'(j);
        end
        emask = '0;
        for (int j = 0; j < n; j++) begin
            if (!c[6]) emask[j] = r[j];
            else if (c[0]) emask[16*j +: 16] = {16{r[j]}};
            else emask[8*j +: 8] = {8{r[j]}};
        end
    endtask

    task automatic apply(input logic [7:0] c, input logic [127:0] a, input logic [127:0] b,
                         input int la, input int lb);
        @(negedge clk);
        ctrl = c; opa = a; opb = b; len_a = 8'(la); len_b = 8'(lb);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int lens[6] = '{0, 3, 8, 16, -5, 100};
        logic [4:0]   eidx;
        logic [127:0] emask, a, b, same;
        logic [4:0]   held_idx;
        string mt;

        rst_n = 1'b0; start = 1'b0; ctrl = '0; opa = '0; opb = '0; len_a = '0; len_b = '0;
        repeat (3) @(negedge clk);
        chk("R12 reset done", 128'(done), 128'(0));
        chk("R12 reset idx",  128'(idx),  128'(0));
        chk("R12 reset mask", mask, 128'(0));
        rst_n = 1'b1;

        // Sweep over every control byte, data pattern and length pair
        for (int c = 0; c < 256; c++) begin
            case (c[3:2])
                2'b00:   mt = "R2 any";
                2'b01:   mt = "R3 ranges";
                2'b10:   mt = "R4 each";
                default: mt = "R5 ordered";
            endcase
            for (int p = 0; p < 3; p++) begin
                for (int ia = 0; ia < 6; ia++) begin
                    for (int ib = 0; ib < 6; ib++) begin
                        if (p == 2) begin
                            a = wide_op(); b = wide_op();
                        end else begin
                            b = small_op();
                            a = (p == 1) ? (b >> 32) : small_op();
                        end
                        apply(8'(c), a, b, lens[ia], lens[ib]);
                        ref_model(8'(c), a, b, lens[ia], lens[ib], eidx, emask);
                        chk("R11 done", 128'(done), 128'(1));
                        chk({mt, " R6 R7 R8 R9 idx"}, 128'(idx), 128'(eidx));
                        chk({mt, " R1 R10 mask"}, mask, emask);
                    end
                end
            end
        end

        // R11: idle cycle clears done and keeps the index
        held_idx = idx;
        @(negedge clk);
        chk("R11 done drop", 128'(done), 128'(0));
        chk("R11 idx hold", 128'(idx), 128'(held_idx));

        // R1: signed vs unsigned range on byte 0 = 0xF0 against [0x80, 0x00]
        a = 128'h0080; b = 128'h00F0;
        apply(8'b0000_0110, a, b, 2, 1);
        chk("R1 signed range", 128'(idx), 128'(0));
        apply(8'b0000_0100, a, b, 2, 1);
        chk("R1 unsigned range", 128'(idx), 128'(16));

        // R6: forcing rules
        apply(8'b0000_1000, wide_op(), wide_op(), 0, 0);
        chk("R6 each both invalid", 128'(idx), 128'(0));
        apply(8'b0000_1000, small_op(), small_op(), 0, 16);
        chk("R6 each A invalid", 128'(idx), 128'(16));
        apply(8'b0000_1100, small_op(), small_op(), 0, 16);
        chk("R6 ordered A invalid", 128'(idx), 128'(0));
        apply(8'b0000_0000, small_op(), small_op(), 0, 0);
        chk("R6 any both invalid", 128'(idx), 128'(16));

        // R7: negative and oversize lengths
        same = wide_op();
        apply(8'b0000_1000, same, same, -3, 100);
        chk("R7 neg length mask", mask, 128'h7);
        apply(8'b0000_1000, same, same, -128, 100);
        chk("R7 saturated length", mask, 128'hFFFF);

        // R8: polarity codes
        apply(8'b0011_1000, same, same, 3, 5);
        chk("R8 masked invert", mask, 128'hFFF8);
        apply(8'b0001_1000, same, same, 3, 5);
        chk("R8 full invert", mask, 128'h0018);
        apply(8'b0010_1000, same, same, 3, 5);
        chk("R8 masked positive", mask, 128'hFFE7);

        // R9 / R10: high index and expanded masks
        apply(8'b0100_1000, same, same, 3, 100);
        chk("R9 msb idx", 128'(idx), 128'(2));
        chk("R10 byte expand", mask, 128'hFF_FFFF);
        apply(8'b0100_1001, same, same, 3, 100);
        chk("R10 word expand", mask, 128'hFFFF_FFFF_FFFF);
        chk("R9 word msb idx", 128'(idx), 128'(2));

        // R11: control bit 7 ignored
        apply(8'b1100_1001, same, same, 3, 100);
        chk("R11 bit7 ignored", mask, 128'hFFFF_FFFF_FFFF);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule